// File: doc/BRIEF.md
# Quadratic Difference-Table Tabulator

This block produces the values of a second-degree polynomial at consecutive integer points without any multiplier. It holds three 32-bit registers: the current value, the first difference and the constant second difference. A single adder, shared between the two registers that change, advances the table by one point per step request.

Software or a sequencer first loads the three starting values. For the default polynomial n*n + n + 41 the starting values are 41, 0 and 2. The block presents the loaded value at once as result number 0. Each later step request takes two clock cycles, and a strobe marks the new value. The first addition moves the first difference forward by adding the second difference. The second addition adds that updated first difference to the value.

Top module: `diff_tabulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `busy`, `overflow`, `out_val` and `out_idx` are all zero.
- R2: A `load` pulse writes `load_f`, `load_d1` and `load_d2`. In the next cycle `out_valid` is 1, `out_val` equals `load_f`, `out_idx` is 0 and `busy` is 0. No addition is performed for this result.
- R3: A step request accepted while `busy` is 0 raises `busy` for exactly the two following cycles. In the cycle after that, `out_valid` is 1 and `busy` is 0.
- R4: Within a step the first difference becomes d1 + d2, and then the value becomes f + (new d1). After loading 41, 0 and 2, the results are 41, 43, 47, 53 and 61, and result n equals n*n + n + 41.
- R5: A step request made while `busy` is 1 is ignored. It produces no extra result and does not change `out_idx`.
- R6: `overflow` becomes 1 when either addition carries out of 32 bits. It stays 1 until the next `load`, which clears it.
- R7: Each result after the loaded one increments `out_idx` by exactly one.
- R8: A `load` during `busy` abandons the step in progress. Only the loaded result appears, and no late result follows.
- R9: `out_valid` lasts one cycle per result, and `out_val` only changes in a cycle where `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Write the starting values and restart the index |
| load_f | input | 32 | Starting value |
| load_d1 | input | 32 | Starting first difference |
| load_d2 | input | 32 | Second difference |
| step | input | 1 | Request the next table point |
| busy | output | 1 | Two-cycle update in progress |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_val | output | 32 | Current table value |
| out_idx | output | 32 | Index of the current result |
| overflow | output | 1 | Sticky carry-out flag |

## Verification
The assertions assume that `load`, `step` and the load values are driven to defined levels from reset onward. The stimulus drives every input low during reset and changes inputs only on falling edges. The timing properties for `busy` and the result index exclude cycles in which `load` is asserted, because a load is allowed to cut a step short. The stimulus deliberately places loads and step requests inside busy windows to exercise those exclusions.

// File: rtl/diff_tabulator.sv
module diff_tabulator #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_f,
  input  logic [W-1:0] load_d1,
  input  logic [W-1:0] load_d2,
  input  logic         step,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] out_val,
  output logic [W-1:0] out_idx,
  output logic         overflow
);

  typedef enum logic [1:0] {IDLE, ADD_D1, ADD_F} phase_t;

  phase_t       ph;
  logic [W-1:0] f_q, d1_q, d2_q, n_q;
  logic [W-1:0] op_a, op_b;
  logic [W:0]   sum;
  logic         vld_q, ovf_q;

  // one adder, operands picked by phase
  assign op_a = (ph == ADD_D1) ? d1_q : f_q;
  assign op_b = (ph == ADD_D1) ? d2_q : d1_q;
  assign sum  = {1'b0, op_a} + {1'b0, op_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= IDLE;
      f_q   <= '0;
      d1_q  <= '0;
      d2_q  <= '0;
      n_q   <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (load) begin
      ph    <= IDLE;
      f_q   <= load_f;
      d1_q  <= load_d1;
      d2_q  <= load_d2;
      n_q   <= '0;
      vld_q <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (ph)
        IDLE:   if (step) ph <= ADD_D1;
        ADD_D1: begin
          d1_q  <= sum[W-1:0];
          ovf_q <= ovf_q | sum[W];
          ph    <= ADD_F;
        end
        ADD_F: begin
          f_q   <= sum[W-1:0];
          ovf_q <= ovf_q | sum[W];
          n_q   <= n_q + 1'b1;
          vld_q <= 1'b1;
          ph    <= IDLE;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  assign busy      = (ph != IDLE);
  assign out_valid = vld_q;
  assign out_val   = f_q;
  assign out_idx   = n_q;
  assign overflow  = ovf_q;

  a_r3_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !load) |=> busy);
  a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);
  a_r3_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(load)) |-> $past(busy));
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !load) |=> overflow);
  a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(load)) |-> (out_idx == $past(out_idx) + 1'b1));
  a_r9_val_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_val));
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !load) |=> !out_valid);

endmodule

// File: tb/diff_tabulator_tb.sv
module diff_tabulator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] load_f = '0, load_d1 = '0, load_d2 = '0;
  logic        step = 1'b0;
  logic        busy, out_valid, overflow;
  logic [31:0] out_val, out_idx;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  diff_tabulator u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_f(load_f),
    .load_d1(load_d1), .load_d2(load_d2), .step(step), .busy(busy),
    .out_valid(out_valid), .out_val(out_val), .out_idx(out_idx),
    .overflow(overflow)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    load = 1'b1; load_f = f; load_d1 = a; load_d2 = b;
    @(negedge clk);
    load = 1'b0;
  endtask

  // issues a step; afterwards the result cycle is current
  task automatic do_step(input logic poke_busy);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = poke_busy;
    chk("R3 busy first", busy, 1);
    chk("R3 no early valid", out_valid, 0);
    @(negedge clk); step = 1'b0;
    chk("R3 busy second", busy, 1);
    @(negedge clk);
    chk("R3 valid", out_valid, 1);
    chk("R3 busy low", busy, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", out_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 value", out_val, 0);
    chk("R1 idx", out_idx, 0);
  endtask

  task automatic t_default_seq();
    longint exp_v [5] = '{41, 43, 47, 53, 61};
    do_load(32'd41, 32'd0, 32'd2);
    chk("R2 valid", out_valid, 1);
    chk("R2 value", out_val, 41);
    chk("R2 idx", out_idx, 0);
    chk("R2 busy", busy, 0);
    for (int i = 1; i < 5; i++) begin
      do_step(1'b0);
      chk("R4 sequence", out_val, exp_v[i]);
      chk("R7 idx", out_idx, i);
    end
    @(negedge clk);
    chk("R9 pulse", out_valid, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] idx0;
    idx0 = out_idx;
    do_step(1'b1);
    chk("R5 one result", out_idx, idx0 + 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 no extra valid", out_valid, 0);
    end
    chk("R5 idx held", out_idx, idx0 + 1);
    chk("R5 value", out_val, 71);
  endtask

  task automatic t_long_run();
    do_load(32'd41, 32'd0, 32'd2);
    for (int n = 1; n <= 300; n++) begin
      do_step(1'b0);
      chk("R4 formula", out_val, longint'(n) * n + n + 41);
    end
    chk("R7 idx 300", out_idx, 300);
    chk("R6 no overflow", overflow, 0);
  endtask

  task automatic t_overflow();
    do_load(32'hFFFF_FFF0, 32'd0, 32'd8);
    do_step(1'b0);
    chk("R6 clear", overflow, 0);
    chk("R6 value", out_val, 32'hFFFF_FFF8);
    do_step(1'b0);
    chk("R6 set f carry", overflow, 1);
    chk("R6 wrap", out_val, 8);
    do_step(1'b0);
    chk("R6 sticky", overflow, 1);
    do_load(32'd5, 32'hFFFF_FFFF, 32'd1);
    chk("R6 load clears", overflow, 0);
    do_step(1'b0);
    chk("R6 set d1 carry", overflow, 1);
    chk("R6 d1 wrap value", out_val, 5);
  endtask

  task automatic t_load_abort();
    do_load(32'd41, 32'd0, 32'd2);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R8 busy", busy, 1);
    load = 1'b1; load_f = 32'd1000; load_d1 = 32'd3; load_d2 = 32'd1;
    @(negedge clk); load = 1'b0;
    chk("R8 valid", out_valid, 1);
    chk("R8 value", out_val, 1000);
    chk("R8 idx", out_idx, 0);
    chk("R8 busy cleared", busy, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 no late result", out_valid, 0);
    end
    do_step(1'b0);
    chk("R8 resume", out_val, 1004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_default_seq();
    t_busy_ignore();
    t_long_run();
    t_overflow();
    t_load_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule